// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the target side of a serial flash interface, limited to the two read commands. It watches chip select, serial clock and serial data in from the host, and drives serial data out together with an output enable. The output enable stands in for the tri-state control of a shared data line: while it is low, the line is high impedance. The serial pins are oversampled by a fast system clock. They pass through a synchronizer, and edges of the serial clock become single-cycle events inside the block.

A transaction opens when chip select falls. The host shifts in an 8-bit command code and a 24-bit address, most significant bit first, one bit per rising serial clock edge. The fast-read command then takes eight more clocks as a dummy byte. After that the block streams bytes from its internal array, most significant bit first, one bit per falling edge. The address steps up after every byte and wraps to zero past the top of the array, so the stream never ends on its own. Raising chip select ends it at any bit.

A command that is not a read, or a read that arrives while the busy input reports a program or erase cycle, leaves the output disabled for the rest of the transaction. The array size is a parameter: `MEM_AW` = 19 gives 4 Mbit (top byte 07FFFFh). The default is smaller so that the array stays small when the block is elaborated on its own.

Top module: `spi_flash_read_responder`

## Requirements
- R1: Array byte at index i holds (29*i + floor(i/256)) mod 256. The byte is chosen by the low `MEM_AW` bits of the 24-bit address, and higher address bits are ignored.
- R2: After chip select falls, the first 8 rising edges shift in the command, MSB first. Code 8'h03 selects normal read.
- R3: Code 8'h0B selects fast read. The 24 address clocks are followed by 8 dummy clocks whose data-in values are ignored, and the output stays disabled during them.
- R4: The first data bit is driven on the falling edge after the last address clock (normal) or the last dummy clock (fast). It is valid at the next rising edge. Each byte is sent MSB first, one bit per falling edge.
- R5: After each data byte the address increments by one. After index 2^MEM_AW-1 it wraps to index 0, and streaming continues while chip select stays low.
- R6: The output enable is low during the command, address and dummy phases. It is high only from the first data bit until chip select rises.
- R7: Any command code other than 8'h03 or 8'h0B keeps the output enable low until chip select rises.
- R8: If busy is high when the eighth command bit is clocked in, the read is rejected and the output enable stays low for the whole transaction.
- R9: Chip select high drops the output enable within 4 system clocks and clears all decode state, even in the middle of a data byte. The next transaction starts from a fresh command.
- R10: During and after the synchronous reset, the output enable and serial data out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_sdi | input | 1 | Serial data in (command, address, dummy) |
| flash_busy | input | 1 | High while a program or erase cycle runs |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_en | output | 1 | Drive enable for serial data out; low means high impedance |

## Verification
A serial clock edge reaches the control logic after two synchronizer stages and one edge register. A new data-out bit therefore appears about four system clocks after the falling edge that launches it. The bench holds each serial clock half-period for eight system clocks and samples data out and its enable just before every rising edge, which is where the host would sample. After chip select rises, the enable is checked six clocks later against the four-clock bound. A monitor also checks the enable on every clock once chip select has been high for five clocks. Expected bytes come from the array formula and the address arithmetic, computed in the bench.

// File: rtl/spi_rd_pkg.sv
`timescale 1ns/1ps
package spi_rd_pkg;

  localparam int          BYTE_W       = 8;
  localparam logic [7:0]  OP_READ      = 8'h03;
  localparam logic [7:0]  OP_READ_FAST = 8'h0B;
  localparam int          DUMMY_CLKS   = 8;

  // transaction phase, advanced by serial clock edges
  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_REJ
  } rd_phase_e;

  // fixed array content: computed per index so no table is stored
  function automatic logic [BYTE_W-1:0] fill_byte(input int unsigned idx);
    return BYTE_W'(idx * 29 + (idx >> 8));
  endfunction

endpackage

// File: rtl/spi_rd_sync.sv
`timescale 1ns/1ps
// Brings chip select, serial clock and data in into the system clock domain
// through equal-length flop chains, then marks serial clock edges.
module spi_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_raw,
  input  logic       sck_raw,
  input  logic       sdi_raw,
  output logic       cs_act,
  output logic       sdi_s,
  output logic       sck_rise,
  output logic       sck_fall
);

  localparam int         LANES   = 3;
  localparam logic [2:0] IDLE_LV = 3'b001;  // {sdi, sck, cs_n}

  logic [LANES-1:0] stg [STAGES];
  logic             sck_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= IDLE_LV;
        else     stg[g] <= {sdi_raw, sck_raw, cs_n_raw};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= IDLE_LV;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= stg[STAGES-1][1];
  end

  assign cs_act   = ~stg[STAGES-1][0];
  assign sdi_s    =  stg[STAGES-1][2];
  assign sck_rise =  stg[STAGES-1][1] & ~sck_d;
  assign sck_fall = ~stg[STAGES-1][1] &  sck_d;

endmodule

// File: rtl/spi_rd_array.sv
`timescale 1ns/1ps
// Read-only byte array with a registered read port (block RAM style).
module spi_rd_array
  import spi_rd_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [BYTE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = fill_byte(i);
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/spi_rd_ctrl.sv
`timescale 1ns/1ps
// Command decode, address capture, dummy skip and data-out shifting.
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int MEM_AW    = 11,
  parameter int ADDR_BITS = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi,
  input  logic              busy,
  input  logic [BYTE_W-1:0] mem_byte,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              sdo,
  output logic              sdo_en
);

  localparam int             CNT_W    = $clog2(ADDR_BITS);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] DUM_LAST = CNT_W'(DUMMY_CLKS - 1);
  localparam int             BIT_W    = $clog2(BYTE_W);

  rd_phase_e          phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-2:0]  cmd_sh;
  logic               fast_q;
  // only the low MEM_AW address bits survive the shift: upper bits fall out
  logic [MEM_AW-1:0]  addr_q;
  logic [BYTE_W-2:0]  out_sh;
  logic [BIT_W-1:0]   bit_q;
  logic               sdo_q;
  logic               en_q;
  logic [BYTE_W-1:0]  cmd_full;

  assign cmd_full = {cmd_sh, sdi};

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      cmd_sh  <= '0;
      fast_q  <= 1'b0;
      addr_q  <= '0;
      out_sh  <= '0;
      bit_q   <= '0;
      sdo_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_CMD: begin
          if (sck_rise) begin
            cmd_sh <= cmd_full[BYTE_W-2:0];
            if (cnt_q == CMD_LAST) begin
              cnt_q <= '0;
              if (busy) begin
                phase_q <= PH_REJ;
              end else if (cmd_full == OP_READ) begin
                phase_q <= PH_ADDR;
                fast_q  <= 1'b0;
              end else if (cmd_full == OP_READ_FAST) begin
                phase_q <= PH_ADDR;
                fast_q  <= 1'b1;
              end else begin
                phase_q <= PH_REJ;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_ADDR: begin
          if (sck_rise) begin
            addr_q <= {addr_q[MEM_AW-2:0], sdi};
            if (cnt_q == ADR_LAST) begin
              cnt_q   <= '0;
              phase_q <= fast_q ? PH_DUMMY : PH_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_DUMMY: begin
          if (sck_rise) begin
            if (cnt_q == DUM_LAST) begin
              cnt_q   <= '0;
              phase_q <= PH_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (sck_fall) begin
            en_q  <= 1'b1;
            bit_q <= bit_q + 1'b1;
            if (bit_q == '0) begin
              sdo_q  <= mem_byte[BYTE_W-1];
              out_sh <= mem_byte[BYTE_W-2:0];
              addr_q <= addr_q + 1'b1;
            end else begin
              sdo_q  <= out_sh[BYTE_W-2];
              out_sh <= {out_sh[BYTE_W-3:0], 1'b0};
            end
          end
        end
        default: ;  // PH_REJ: wait for chip select to rise
      endcase
    end
  end

  assign mem_addr = addr_q;
  assign sdo      = sdo_q;
  assign sdo_en   = en_q;

  // R6: the drive enable is only ever set while streaming data
  a_r6_en_only_in_data: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (phase_q == PH_DATA));

  // R7: a rejected transaction never drives the line
  a_r7_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_REJ) |-> !en_q);

  // R8: busy at the last command bit forces rejection
  a_r8_busy_rejects: assert property (@(posedge clk) disable iff (rst)
    (cs_act && phase_q == PH_CMD && sck_rise && cnt_q == CMD_LAST && busy)
      |=> (phase_q == PH_REJ));

  // R9: released chip select clears the enable and the phase
  a_r9_release_clears: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!en_q && phase_q == PH_CMD));

  // R5: the byte index wraps from its top value to zero
  a_r5_index_wraps: assert property (@(posedge clk) disable iff (rst)
    (cs_act && phase_q == PH_DATA && sck_fall && bit_q == '0 && addr_q == '1)
      |=> (addr_q == '0));

endmodule

// File: rtl/spi_flash_read_responder.sv
`timescale 1ns/1ps
module spi_flash_read_responder
  import spi_rd_pkg::*;
#(
  parameter int MEM_AW      = 11,
  parameter int ADDR_BITS   = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_sdi,
  input  logic flash_busy,
  output logic spi_sdo,
  output logic spi_sdo_en
);

  logic              cs_act;
  logic              sdi_s;
  logic              sck_rise;
  logic              sck_fall;
  logic [MEM_AW-1:0] mem_addr;
  logic [BYTE_W-1:0] mem_byte;

  spi_rd_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .cs_n_raw (spi_cs_n),
    .sck_raw  (spi_sck),
    .sdi_raw  (spi_sdi),
    .cs_act   (cs_act),
    .sdi_s    (sdi_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  spi_rd_array #(
    .MEM_AW (MEM_AW)
  ) u_array (
    .clk     (clk),
    .rd_addr (mem_addr),
    .rd_data (mem_byte)
  );

  spi_rd_ctrl #(
    .MEM_AW    (MEM_AW),
    .ADDR_BITS (ADDR_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cs_act   (cs_act),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sdi      (sdi_s),
    .busy     (flash_busy),
    .mem_byte (mem_byte),
    .mem_addr (mem_addr),
    .sdo      (spi_sdo),
    .sdo_en   (spi_sdo_en)
  );

  // R10: reset leaves the output quiet
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!spi_sdo_en && !spi_sdo));

endmodule

// File: tb/spi_flash_read_responder_bench.sv
`timescale 1ns/1ps
module spi_flash_read_responder_bench;

  localparam int MEM_AW = 11;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int HALF   = 8;   // system clocks per serial clock half-period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic busy = 1'b0;
  logic sdo;
  logic sdo_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  int idle_run = 0;

  always #2.5 clk = ~clk;

  spi_flash_read_responder #(.MEM_AW(MEM_AW)) u_spi_flash_read_responder (
    .clk        (clk),
    .rst        (rst),
    .spi_cs_n   (cs_n),
    .spi_sck    (sck),
    .spi_sdi    (sdi),
    .flash_busy (busy),
    .spi_sdo    (sdo),
    .spi_sdo_en (sdo_en)
  );

  function automatic logic [7:0] pat(input int idx);
    return 8'((idx * 29 + idx / 256) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // idle monitor, every clock: chip select high for 5+ clocks -> no drive (R9)
  always @(negedge clk) begin
    if (mon_on) begin
      if (cs_n) idle_run++;
      else      idle_run = 0;
      if (idle_run >= 5) chk(sdo_en === 1'b0, "R9", "idle sdo_en", int'(sdo_en), 0);
    end
  end

  // one serial bit slot: falling edge, settle, host sample, rising edge
  task automatic slot(input logic din, input logic exp_en, input logic exp_d,
                      input string req);
    @(negedge clk);
    sck = 1'b0;
    sdi = din;
    repeat (HALF) @(negedge clk);
    chk(sdo_en === exp_en, req, "sdo_en", int'(sdo_en), int'(exp_en));
    if (exp_en) chk(sdo === exp_d, req, "sdo", int'(sdo), int'(exp_d));
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  // full transaction; cut_bits >= 0 raises chip select after that many data bits
  task automatic txn(input logic [7:0] cmd, input logic [23:0] addr,
                     input int nbytes, input logic bsy, input int cut_bits,
                     input string dreq);
    bit fast = (cmd == 8'h0B);
    bit rej  = bsy || !((cmd == 8'h03) || (cmd == 8'h0B));
    string rreq = bsy ? "R8" : "R7";
    int idx = int'(addr) % DEPTH;
    int sent = 0;
    bit stop = 1'b0;
    @(negedge clk);
    busy = bsy;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 7; i >= 0; i--) slot(cmd[i], 1'b0, 1'b0, "R2");
    busy = 1'b0;
    for (int i = 23; i >= 0; i--) slot(addr[i], 1'b0, 1'b0, rej ? rreq : "R6");
    if (fast && !rej)
      for (int i = 0; i < 8; i++) slot(i[0], 1'b0, 1'b0, "R3");
    for (int b = 0; b < nbytes && !stop; b++) begin
      logic [7:0] e = pat(idx);
      for (int k = 7; k >= 0; k--) begin
        if (cut_bits >= 0 && sent == cut_bits) begin
          stop = 1'b1;
          break;
        end
        slot(1'b0, !rej, rej ? 1'b0 : e[k], rej ? rreq : dreq);
        sent++;
      end
      idx = (idx + 1) % DEPTH;
    end
    @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sdo_en === 1'b0, "R9", "sdo_en after release", int'(sdo_en), 0);
    sck = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sdo_en === 1'b0, "R10", "sdo_en in reset", int'(sdo_en), 0);
    chk(sdo === 1'b0, "R10", "sdo in reset", int'(sdo), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(sdo_en === 1'b0, "R10", "sdo_en after reset", int'(sdo_en), 0);
    chk(sdo === 1'b0, "R10", "sdo after reset", int'(sdo), 0);
    mon_on = 1'b1;

    // R2 R4 R5: normal read, four bytes
    txn(8'h03, 24'h000010, 4, 1'b0, -1, "R4");
    // R3: fast read with a dummy byte
    txn(8'h0B, 24'h0000A5, 3, 1'b0, -1, "R3");
    // R5: wrap past the top index
    txn(8'h03, 24'(DEPTH - 2), 4, 1'b0, -1, "R5");
    // R5: fast read wrap
    txn(8'h0B, 24'(DEPTH - 1), 2, 1'b0, -1, "R5");
    // R1: upper address bits ignored
    txn(8'h03, 24'hFFF805, 2, 1'b0, -1, "R1");
    // R7: unsupported codes
    txn(8'h05, 24'h000010, 2, 1'b0, -1, "R7");
    txn(8'h0A, 24'h000020, 1, 1'b0, -1, "R7");
    // R8: reads while busy
    txn(8'h03, 24'h000030, 2, 1'b1, -1, "R8");
    txn(8'h0B, 24'h000040, 2, 1'b1, -1, "R8");
    // R9: chip select raised mid-byte, then a clean new read
    txn(8'h03, 24'h000123, 2, 1'b0, 3, "R9");
    txn(8'h03, 24'h000200, 2, 1'b0, -1, "R9");
    txn(8'h0B, 24'h000301, 2, 1'b0, 11, "R9");
    txn(8'h0B, 24'h0007F0, 1, 1'b0, -1, "R4");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule